// File: doc/BRIEF.md
# Serial-In Parallel-Out Shift Register with Output Store

This block takes a serial bit stream and turns it into a parallel word. It has two stages. The first is a shift chain. Each rising edge of its own clock moves the chain up one position and takes the serial input into the lowest stage. The second is a store bank. Each rising edge of a separate storage clock copies the whole chain into it in one step. Only the store bank drives the parallel outputs. The chain can therefore be refilled in the background while the outputs keep the last word that was committed.

Each stage has its own asynchronous active-low clear. A clear forces its own stage to zero at once, with no clock edge needed, and holds it there for as long as it stays low. A cascade output carries the top stage of the chain. Feeding it into the serial input of a second instance builds a longer converter. When one signal drives both clocks, the store bank takes the chain contents from before that edge, so it always lags the chain by one shift.

Top module: `serial_shift_store`

## Requirements
- R1: On each rising edge of `sh_clk`, with `sh_clr_n` high, stage 0 of the chain takes `ser_in` without inversion.
- R2: On each rising edge of `sh_clk`, stage i takes the previous value of stage i-1. After eight shifts the first bit shifted in sits at bit 7 of the chain and the last one at bit 0.
- R3: On each rising edge of `st_clk`, with `st_clr_n` high, `par_out` takes all chain stages in parallel, with chain bit i on `par_out[i]`. Between storage edges `par_out` does not change, whatever shifts take place.
- R4: While `sh_clr_n` is low, every chain stage and `cascade_out` are 0 without any clock edge, and `sh_clk` edges have no effect.
- R5: While `st_clr_n` is low, `par_out` is 0 without any clock edge, and `st_clk` edges have no effect.
- R6: `cascade_out` always equals chain stage 7, and the storage clock and storage clear have no effect on it.
- R7: A shift clear does not change `par_out`, and a storage clear does not change the chain.
- R8: When `sh_clk` and `st_clk` rise together, `par_out` takes the chain contents from before that edge.
- R9: Two instances chained through `cascade_out` act as one 16-bit converter. After 16 shifts, sent most significant bit first, and one storage edge, the first instance's `par_out` holds the low byte and the second instance's `par_out` holds the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data entering chain stage 0 |
| sh_clk | input | 1 | Shift clock, rising edge |
| st_clk | input | 1 | Storage clock, rising edge |
| sh_clr_n | input | 1 | Asynchronous active-low clear of the chain |
| st_clr_n | input | 1 | Asynchronous active-low clear of the store bank |
| par_out | output | 8 | Parallel word held in the store bank |
| cascade_out | output | 1 | Top chain stage, used for chaining |

## Verification
A shift and a store can happen on the same edge. The bench provokes this by raising both clocks from one statement, after it has loaded a known byte with separate shift pulses. The result passes only if `par_out` shows that byte rather than the shifted one, and a second tied pulse must then show the byte as shifted by the first. The checker confirms the same lag on every storage edge. It compares `par_out` with the chain value sampled at the previous storage edge.

// File: rtl/srg_pkg.sv
// Package: shared sizing for the serial-to-parallel store block.
// Assumes nothing beyond a width of at least two stages.
package srg_pkg;
    localparam int unsigned SRG_DEF_WIDTH = 8;
    localparam int unsigned SRG_MIN_WIDTH = 2;
endpackage

// File: rtl/srg_shift_chain.sv
// Module: shift chain of WIDTH flip-flops with an asynchronous active-low clear.
// Stage 0 takes din on each rising clk edge, and every higher stage takes its lower neighbour.
// Assumes clr_n is glitch-free, because it acts without a clock.
module srg_shift_chain #(
    parameter int unsigned WIDTH = srg_pkg::SRG_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stages,
    output logic             tail
);
    localparam int unsigned TOP = WIDTH - 1;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            if (i == 0) begin : g_entry
                // Entry stage: capture the serial input.
                always_ff @(posedge clk or negedge clr_n) begin
                    if (!clr_n) stages[i] <= 1'b0;
                    else        stages[i] <= din;
                end
            end else begin : g_link
                // Link stage: take the neighbour below.
                always_ff @(posedge clk or negedge clr_n) begin
                    if (!clr_n) stages[i] <= 1'b0;
                    else        stages[i] <= stages[i-1];
                end
            end
        end
    endgenerate

    // Cascade tap: the top stage leaves the block.
    assign tail = stages[TOP];
endmodule

// File: rtl/srg_store_bank.sv
// Module: parallel store register with an asynchronous active-low clear.
// Copies d into q on each rising clk edge.
// Assumes d is stable around the edge. When d comes from a chain clocked by the same edge,
// the value before that edge is the one stored.
module srg_store_bank #(
    parameter int unsigned WIDTH = srg_pkg::SRG_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Store process: parallel load, or clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/serial_shift_store.sv
// Module: serial-in, parallel-out converter with an output store.
// Joins the shift chain to the store bank. The clocks and clears are independent,
// and the cascade output comes straight from the chain.
// Assumes both clears are asynchronous and active low.
module serial_shift_store #(
    parameter int unsigned WIDTH = srg_pkg::SRG_DEF_WIDTH
) (
    input  logic             ser_in,
    input  logic             sh_clk,
    input  logic             st_clk,
    input  logic             sh_clr_n,
    input  logic             st_clr_n,
    output logic [WIDTH-1:0] par_out,
    output logic             cascade_out
);
    logic [WIDTH-1:0] shift_q;

    // Shift chain instance.
    srg_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (sh_clk),
        .clr_n  (sh_clr_n),
        .din    (ser_in),
        .stages (shift_q),
        .tail   (cascade_out)
    );

    // Store bank instance.
    srg_store_bank #(.WIDTH(WIDTH)) u_store (
        .clk   (st_clk),
        .clr_n (st_clr_n),
        .d     (shift_q),
        .q     (par_out)
    );
endmodule

// File: rtl/srg_checker.sv
// Module: property checker for serial_shift_store, attached by bind.
// Each "seen" flag shows that a clock edge has come since that stage's last clear.
// The flags keep history-based checks quiet across clear pulses that fall between edges.
module srg_checker #(
    parameter int unsigned WIDTH = srg_pkg::SRG_DEF_WIDTH
) (
    input logic             ser_in,
    input logic             sh_clk,
    input logic             st_clk,
    input logic             sh_clr_n,
    input logic             st_clr_n,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] par_out,
    input logic             cascade_out
);
    logic sh_seen;
    logic st_seen;

    // Shift history flag: set by a shift edge, cleared by the chain clear.
    always_ff @(posedge sh_clk or negedge sh_clr_n) begin
        if (!sh_clr_n) sh_seen <= 1'b0;
        else           sh_seen <= 1'b1;
    end

    // Store history flag: set by a storage edge, cleared by the store clear.
    always_ff @(posedge st_clk or negedge st_clr_n) begin
        if (!st_clr_n) st_seen <= 1'b0;
        else           st_seen <= 1'b1;
    end

    // R1
    serial_entry_chk: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
        sh_seen |-> shift_q[0] == $past(ser_in));

    // R2
    stage_advance_chk: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
        sh_seen |-> cascade_out == $past(shift_q[WIDTH-2]));

    // R3
    parallel_copy_chk: assert property (@(posedge st_clk) disable iff (!st_clr_n)
        st_seen |-> par_out == $past(shift_q));

    // R4
    chain_clear_chk: assert property (@(posedge sh_clk)
        !sh_clr_n |-> (shift_q == '0 && cascade_out == 1'b0));

    // R5
    store_clear_chk: assert property (@(posedge st_clk)
        !st_clr_n |-> par_out == '0);
endmodule

bind serial_shift_store srg_checker #(.WIDTH(WIDTH)) u_chk (
    .ser_in      (ser_in),
    .sh_clk      (sh_clk),
    .st_clk      (st_clk),
    .sh_clr_n    (sh_clr_n),
    .st_clr_n    (st_clr_n),
    .shift_q     (shift_q),
    .par_out     (par_out),
    .cascade_out (cascade_out)
);

// File: tb/sim_serial_shift_store.sv
// Bench: two chained instances. Clocks are pulsed by tasks; expected values come from byte arithmetic.
module sim_serial_shift_store;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    logic       din, sh_clk, st_clk, sh_clr_n, st_clr_n;
    logic [7:0] par0, par1;
    logic       casc0, casc1;
    int         checks, errs;

    serial_shift_store u0 (.ser_in(din), .sh_clk(sh_clk), .st_clk(st_clk),
        .sh_clr_n(sh_clr_n), .st_clr_n(st_clr_n), .par_out(par0), .cascade_out(casc0));
    serial_shift_store u1 (.ser_in(casc0), .sh_clk(sh_clk), .st_clk(st_clk),
        .sh_clr_n(sh_clr_n), .st_clr_n(st_clr_n), .par_out(par1), .cascade_out(casc1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic shift1(input logic b);
        din = b;
        #HALF sh_clk = 1'b1;
        #HALF sh_clk = 1'b0;
    endtask

    task automatic shift_byte(input logic [7:0] v);
        for (int b = 7; b >= 0; b--) shift1(v[b]);
    endtask

    task automatic store1();
        #HALF st_clk = 1'b1;
        #HALF st_clk = 1'b0;
    endtask

    task automatic tied1(input logic b);
        din = b;
        #HALF begin sh_clk = 1'b1; st_clk = 1'b1; end
        #HALF begin sh_clk = 1'b0; st_clk = 1'b0; end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        checks = 0; errs = 0;
        din = 0; sh_clk = 0; st_clk = 0; sh_clr_n = 0; st_clr_n = 0;
        #CLK_PERIOD;
        chk("R4 reset cascade", casc0, 1'b0);
        chk("R5 reset parallel", par0, 8'h00);
        sh_clr_n = 1; st_clr_n = 1;
        #CLK_PERIOD;

        // Exhaustive byte sweep through the chained pair.
        prev = 8'h00;
        for (int v = 0; v < 256; v++) begin
            shift_byte(v[7:0]);
            chk("R6 cascade is top stage", casc0, v[7]);
            chk("R3 parallel held between stores", par0, prev);
            store1();
            chk("R1 R2 parallel byte", par0, v[7:0]);
            chk("R9 chained high byte", par1, prev);
            prev = v[7:0];
        end

        // 16-bit word through both devices.
        shift_byte(8'hA5); shift_byte(8'hC3); store1();
        chk("R9 sixteen bits", {par1, par0}, 16'hA5C3);

        // Tied clocks: store lags the chain by one shift.
        shift_byte(8'h3C);
        tied1(1'b1);
        chk("R8 tied first edge", par0, 8'h3C);
        tied1(1'b0);
        chk("R8 tied second edge", par0, 8'h79);

        // Shift clear: asynchronous, dominant, leaves the store alone.
        shift_byte(8'h5A); store1();
        sh_clr_n = 0; #1;
        chk("R4 async chain clear", casc0, 1'b0);
        shift_byte(8'hFF);
        chk("R4 clocks ignored in clear", casc0, 1'b0);
        chk("R7 store kept over chain clear", par0, 8'h5A);
        sh_clr_n = 1; #1;
        store1();
        chk("R4 chain empty after clear", par0, 8'h00);

        // Store clear: asynchronous, dominant, leaves the chain alone.
        shift_byte(8'h81); store1();
        chk("R3 load before store clear", par0, 8'h81);
        st_clr_n = 0; #1;
        chk("R5 async store clear", par0, 8'h00);
        chk("R6 cascade kept over store clear", casc0, 1'b1);
        store1();
        chk("R5 storage edge ignored in clear", par0, 8'h00);
        st_clr_n = 1; #1;
        chk("R5 stays zero until store", par0, 8'h00);
        store1();
        chk("R7 chain kept over store clear", par0, 8'h81);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule